// File: doc/BRIEF.md
# Modulo-Scheduled Loop Branch Controller

This block resolves the counted loop branch that closes a software-pipelined loop. Software loads two counters before the loop: an iteration count and a drain count. It also seeds a bank of one-bit predicates so that only the lowest rotating predicate is set. Each time the loop branch executes, the controller decides whether the branch is taken and steps the matching counter. It shifts a fresh stage predicate into the lowest rotating predicate and rotates the rename base of the rotating general-register region. Each loop stage is guarded by one rotating predicate. Pipeline fill and drain then fall out of the predicate pattern, and no separate prologue or epilogue code is needed.

While iterations remain, the branch is taken and ones are fed into the predicate bank. Once the iteration count is spent, the branch keeps being taken while the drain count is above one, and zeros are fed in so that the older stages finish. The branch falls through when the drain runs out. A combinational lookup port translates a logical general-register index into its physical index under the current rename base.

Top module: `loop_branch_ctl`

## Requirements
- R1: After reset, the iteration count, drain count and rename base are all 0. Predicate 0 reads 1 and every other predicate reads 0.
- R2: A write strobe loads its counter from the write data on the next clock edge. If a branch occurs in the same cycle, the written value wins for that counter.
- R3: Kernel case. When a branch occurs with a nonzero iteration count, `br_taken` is 1 in that cycle. The iteration count then drops by 1, the drain count is unchanged, and predicate 16 becomes 1.
- R4: Drain case. When a branch occurs with a zero iteration count and a drain count above 1, `br_taken` is 1. The drain count then drops by 1, the iteration count stays 0, and predicate 16 becomes 0.
- R5: Exit case. When a branch occurs with a zero iteration count and a drain count of 0 or 1, `br_taken` is 0. The drain count becomes 0, predicate 16 becomes 0, and rotation still takes place.
- R6: On every branch, predicate k+1 takes the old value of predicate k for k = 16 to 62, and the old predicate 63 is dropped.
- R7: Branches never change predicates 1 to 15. Predicate 0 reads 1 at all times, including after a bank write whose bit 0 is 0.
- R8: Every branch lowers the rename base by 1, modulo 96, so that 0 wraps to 95.
- R9: For a logical index i below 32, the physical index is i. For i from 32 to 127, the physical index is 32 + ((i - 32 + base) mod 96).
- R10: A predicate bank write loads bits 63 to 1 from the write data on the next edge, with bit n holding predicate n. In a cycle that also has a branch, the write takes precedence over the shift, but the rename base still rotates.
- R11: With no branch and no write strobe, the counters, the predicates and the rename base hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lc_wr_en | input | 1 | Iteration count write strobe |
| lc_wr_data | input | LC_W | Iteration count write value |
| ec_wr_en | input | 1 | Drain count write strobe |
| ec_wr_data | input | EC_W | Drain count write value |
| pr_wr_en | input | 1 | Predicate bank write strobe |
| pr_wr_data | input | NUM_PRED | Predicate bank write value, bit n is predicate n |
| br_valid | input | 1 | A loop branch executes this cycle |
| br_taken | output | 1 | The branch in this cycle is taken |
| lc_q | output | LC_W | Current iteration count |
| ec_q | output | EC_W | Current drain count |
| pred_q | output | NUM_PRED | Current predicate values |
| rrb_q | output | RRB_W | Current rename base |
| map_log_idx | input | GR_W | Logical general-register index to translate |
| map_phys_idx | output | GR_W | Physical index for `map_log_idx` |

## Verification
The hardest situation to reach from the ports is a long predicate pattern. In that pattern, the ones from the kernel iterations and the zeros from the drain iterations sit side by side in the rotating bank, and the rename base has already wrapped through zero. To get there, the stimulus sweeps every pair of starting iteration and drain counts from 0 to 5. For each pair it reseeds the predicate bank and issues branches until one past the fall-through. At every step it checks the whole predicate vector against a closed-form position rule. Because the sweep has many steps, the rename base wraps several times, and the index translation is then checked over all 128 indices at a nonzero base.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

   // Classification of a loop branch from the current counters
   typedef enum logic [1:0] {
      BK_KERNEL = 2'd0,
      BK_DRAIN  = 2'd1,
      BK_EXIT   = 2'd2
   } br_kind_e;

   function automatic logic kind_taken(br_kind_e k);
      return (k != BK_EXIT);
   endfunction

   function automatic logic kind_fill(br_kind_e k);
      return (k == BK_KERNEL);
   endfunction

endpackage

// File: rtl/lbc_counters.sv
module lbc_counters
   import lbc_pkg::*;
#(
   parameter int LC_W = 16,
   parameter int EC_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lc_wr_en,
   input  logic [LC_W-1:0] lc_wr_data,
   input  logic            ec_wr_en,
   input  logic [EC_W-1:0] ec_wr_data,
   input  logic            br_valid,
   output logic            br_taken,
   output logic            fill_bit,
   output logic [LC_W-1:0] lc_q,
   output logic [EC_W-1:0] ec_q
);

   br_kind_e        kind;
   logic [LC_W-1:0] lc_nxt;
   logic [EC_W-1:0] ec_nxt;

   always_comb begin
      if (lc_q != '0)
         kind = BK_KERNEL;
      else if (ec_q > EC_W'(1))
         kind = BK_DRAIN;
      else
         kind = BK_EXIT;
   end

   assign br_taken = br_valid & kind_taken(kind);
   assign fill_bit = kind_fill(kind);

   always_comb begin
      lc_nxt = lc_q;
      ec_nxt = ec_q;
      if (br_valid) begin
         if (kind == BK_KERNEL)
            lc_nxt = lc_q - LC_W'(1);
         else if (ec_q != '0)
            ec_nxt = ec_q - EC_W'(1);
      end
      if (lc_wr_en) lc_nxt = lc_wr_data;
      if (ec_wr_en) ec_nxt = ec_wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lc_q <= '0;
         ec_q <= '0;
      end else begin
         lc_q <= lc_nxt;
         ec_q <= ec_nxt;
      end
   end

   // R3
   lc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !lc_wr_en && !ec_wr_en && lc_q != '0)
         |=> (lc_q == $past(lc_q) - LC_W'(1)) && (ec_q == $past(ec_q)));

   // R4
   ec_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !lc_wr_en && !ec_wr_en && lc_q == '0 && ec_q > EC_W'(1))
         |=> (ec_q == $past(ec_q) - EC_W'(1)) && (lc_q == '0));

   // R5
   exit_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && lc_q == '0 && ec_q <= EC_W'(1)) |-> !br_taken);

   // R5
   exit_ec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !ec_wr_en && lc_q == '0 && ec_q <= EC_W'(1)) |=> (ec_q == '0));

   // R11
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && !lc_wr_en && !ec_wr_en) |=> $stable(lc_q) && $stable(ec_q));

endmodule

// File: rtl/lbc_pred_rot.sv
module lbc_pred_rot #(
   parameter int NUM_PRED        = 64,
   parameter int NUM_STATIC_PRED = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_en,
   input  logic                fill_bit,
   input  logic                wr_en,
   input  logic [NUM_PRED-1:0] wr_data,
   output logic [NUM_PRED-1:0] pred_q
);

   localparam int S = NUM_STATIC_PRED;
   localparam int N = NUM_PRED;

   logic [N-1:0] bank;
   logic [N-1:0] shifted;

   // Static part is untouched; the rotating part moves up one place
   assign shifted = {bank[N-2:S], fill_bit, bank[S-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n)
         bank <= N'(1);
      else if (wr_en)
         bank <= {wr_data[N-1:1], 1'b1};
      else if (shift_en)
         bank <= shifted;
   end

   assign pred_q = bank;

   // R3
   fill_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !wr_en) |=> (pred_q[S] == $past(fill_bit)));

   // R6
   rot_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !wr_en) |=> (pred_q[N-1:S+1] == $past(pred_q[N-2:S])));

   // R7
   static_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !wr_en) |=> (pred_q[S-1:0] == $past(pred_q[S-1:0])));

   // R10
   wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (pred_q[N-1:1] == $past(wr_data[N-1:1])));

endmodule

// File: rtl/lbc_rename.sv
module lbc_rename #(
   parameter int NUM_GR      = 128,
   parameter int GR_ROT_BASE = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              rot_en,
   input  logic [$clog2(NUM_GR)-1:0]         log_idx,
   output logic [$clog2(NUM_GR)-1:0]         phys_idx,
   output logic [$clog2(NUM_GR-GR_ROT_BASE)-1:0] rrb_q
);

   localparam int ROT_SIZE = NUM_GR - GR_ROT_BASE;
   localparam int RRB_W    = $clog2(ROT_SIZE);
   localparam int GR_W     = $clog2(NUM_GR);
   localparam bit IS_POW2  = ((1 << RRB_W) == ROT_SIZE);

   logic [RRB_W-1:0] rrb;
   logic [GR_W-1:0]  offset;
   logic [RRB_W-1:0] wrapped;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rrb <= '0;
      else if (rot_en)
         rrb <= (rrb == '0) ? RRB_W'(ROT_SIZE - 1) : rrb - RRB_W'(1);
   end

   assign rrb_q  = rrb;
   assign offset = log_idx - GR_W'(GR_ROT_BASE);

   generate
      if (IS_POW2) begin : g_mask
         assign wrapped = offset[RRB_W-1:0] + rrb;
      end else begin : g_fold
         logic [RRB_W:0] sum;
         assign sum     = {1'b0, offset[RRB_W-1:0]} + {1'b0, rrb};
         assign wrapped = (sum >= (RRB_W+1)'(ROT_SIZE))
                          ? RRB_W'(sum - (RRB_W+1)'(ROT_SIZE)) : sum[RRB_W-1:0];
      end
   endgenerate

   assign phys_idx = (log_idx < GR_W'(GR_ROT_BASE)) ? log_idx
                     : GR_W'(GR_ROT_BASE) + GR_W'(wrapped);

   // R8
   rrb_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rot_en |=> (rrb_q != $past(rrb_q)));

   // R8
   rrb_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_en && rrb_q == '0) |=> (rrb_q == RRB_W'(ROT_SIZE - 1)));

   // R11
   rrb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rot_en |=> $stable(rrb_q));

   // R9
   map_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (log_idx >= GR_W'(GR_ROT_BASE)) |-> (phys_idx >= GR_W'(GR_ROT_BASE)));

endmodule

// File: rtl/loop_branch_ctl.sv
module loop_branch_ctl #(
   parameter int LC_W            = 16,
   parameter int EC_W            = 6,
   parameter int NUM_PRED        = 64,
   parameter int NUM_STATIC_PRED = 16,
   parameter int NUM_GR          = 128,
   parameter int GR_ROT_BASE     = 32,
   localparam int RRB_W          = $clog2(NUM_GR - GR_ROT_BASE),
   localparam int GR_W           = $clog2(NUM_GR)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lc_wr_en,
   input  logic [LC_W-1:0]     lc_wr_data,
   input  logic                ec_wr_en,
   input  logic [EC_W-1:0]     ec_wr_data,
   input  logic                pr_wr_en,
   input  logic [NUM_PRED-1:0] pr_wr_data,
   input  logic                br_valid,
   output logic                br_taken,
   output logic [LC_W-1:0]     lc_q,
   output logic [EC_W-1:0]     ec_q,
   output logic [NUM_PRED-1:0] pred_q,
   output logic [RRB_W-1:0]    rrb_q,
   input  logic [GR_W-1:0]     map_log_idx,
   output logic [GR_W-1:0]     map_phys_idx
);

   generate
      if (NUM_STATIC_PRED < 1 || NUM_STATIC_PRED > NUM_PRED - 2) begin : g_bad_pred
         $error("static predicate count out of range");
      end
      if (GR_ROT_BASE < 1 || NUM_GR - GR_ROT_BASE < 2) begin : g_bad_gr
         $error("rotating register region out of range");
      end
      if (LC_W < 1 || EC_W < 2) begin : g_bad_cnt
         $error("counter widths too small");
      end
   endgenerate

   logic fill_bit;

   lbc_counters #(
      .LC_W (LC_W),
      .EC_W (EC_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .lc_wr_en   (lc_wr_en),
      .lc_wr_data (lc_wr_data),
      .ec_wr_en   (ec_wr_en),
      .ec_wr_data (ec_wr_data),
      .br_valid   (br_valid),
      .br_taken   (br_taken),
      .fill_bit   (fill_bit),
      .lc_q       (lc_q),
      .ec_q       (ec_q)
   );

   lbc_pred_rot #(
      .NUM_PRED        (NUM_PRED),
      .NUM_STATIC_PRED (NUM_STATIC_PRED)
   ) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (br_valid),
      .fill_bit (fill_bit),
      .wr_en    (pr_wr_en),
      .wr_data  (pr_wr_data),
      .pred_q   (pred_q)
   );

   lbc_rename #(
      .NUM_GR      (NUM_GR),
      .GR_ROT_BASE (GR_ROT_BASE)
   ) u_ren (
      .clk      (clk),
      .rst_n    (rst_n),
      .rot_en   (br_valid),
      .log_idx  (map_log_idx),
      .phys_idx (map_phys_idx),
      .rrb_q    (rrb_q)
   );

   // R7
   pred_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pr_wr_en |=> pred_q[0]);

   // R3
   kernel_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && lc_q != '0) |-> br_taken);

endmodule

// File: tb/tb_loop_branch_ctl.sv
module tb_loop_branch_ctl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lc_wr_en, ec_wr_en, pr_wr_en, br_valid;
   logic [15:0] lc_wr_data;
   logic [5:0]  ec_wr_data;
   logic [63:0] pr_wr_data;
   logic        br_taken;
   logic [15:0] lc_q;
   logic [5:0]  ec_q;
   logic [63:0] pred_q;
   logic [6:0]  rrb_q;
   logic [6:0]  map_log_idx, map_phys_idx;

   int checks = 0;
   int failures = 0;
   int rrb_exp = 0;
   bit done = 0;

   always #5 clk = ~clk;

   loop_branch_ctl dut (
      .clk(clk), .rst_n(rst_n),
      .lc_wr_en(lc_wr_en), .lc_wr_data(lc_wr_data),
      .ec_wr_en(ec_wr_en), .ec_wr_data(ec_wr_data),
      .pr_wr_en(pr_wr_en), .pr_wr_data(pr_wr_data),
      .br_valid(br_valid), .br_taken(br_taken),
      .lc_q(lc_q), .ec_q(ec_q), .pred_q(pred_q), .rrb_q(rrb_q),
      .map_log_idx(map_log_idx), .map_phys_idx(map_phys_idx)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected predicate vector after j branches from seed {p16, p5, p0}
   function automatic logic [63:0] pred_model(int j, int lc0);
      logic [63:0] v;
      v = 64'h21;
      for (int k = 0; k < 48; k++) begin
         if (k < j) v[16+k] = ((j - 1 - k) < lc0);
         else       v[16+k] = (k == j);
      end
      return v;
   endfunction

   task automatic branch_step(output logic taken);
      @(negedge clk);
      br_valid = 1'b1;
      #1 taken = br_taken;
      @(negedge clk);
      br_valid = 1'b0;
      rrb_exp = (rrb_exp + 95) % 96;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic tk;
      int drain_taken, nsteps;
      logic [63:0] snap_p;
      logic [15:0] snap_l;
      rst_n = 1'b0;
      lc_wr_en = 0; ec_wr_en = 0; pr_wr_en = 0; br_valid = 0;
      lc_wr_data = '0; ec_wr_data = '0; pr_wr_data = '0; map_log_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 lc", 64'(lc_q), 64'd0);
      chk("R1 ec", 64'(ec_q), 64'd0);
      chk("R1 rrb", 64'(rrb_q), 64'd0);
      chk("R1 pred", pred_q, 64'h1);

      // Sweep of starting counts: R2 R3 R4 R5 R6 R7 R8 R10
      for (int lc0 = 0; lc0 <= 5; lc0++) begin
         for (int ec0 = 0; ec0 <= 5; ec0++) begin
            @(negedge clk);
            lc_wr_en = 1; lc_wr_data = 16'(lc0);
            ec_wr_en = 1; ec_wr_data = 6'(ec0);
            pr_wr_en = 1; pr_wr_data = (64'h1 << 16) | (64'h1 << 5);
            @(negedge clk);
            lc_wr_en = 0; ec_wr_en = 0; pr_wr_en = 0;
            chk("R2 lc load", 64'(lc_q), 64'(lc0));
            chk("R2 ec load", 64'(ec_q), 64'(ec0));
            chk("R10 R7 pred seed", pred_q, 64'h10021);
            drain_taken = (ec0 > 1) ? ec0 - 1 : 0;
            nsteps = lc0 + drain_taken + 2;
            for (int j = 1; j <= nsteps; j++) begin
               branch_step(tk);
               chk((j <= lc0) ? "R3 taken" : "R4 R5 taken",
                   64'(tk), 64'(j <= lc0 + drain_taken));
               chk("R3 R4 lc", 64'(lc_q), 64'((j <= lc0) ? lc0 - j : 0));
               chk("R4 R5 ec", 64'(ec_q),
                   64'((j <= lc0) ? ec0 : ((ec0 - (j - lc0)) > 0 ? ec0 - (j - lc0) : 0)));
               chk("R6 R7 pred", pred_q, pred_model(j, lc0));
               chk("R8 rrb", 64'(rrb_q), 64'(rrb_exp));
            end
         end
      end

      // R9 index translation at the current base
      for (int i = 0; i < 128; i++) begin
         map_log_idx = 7'(i);
         #1;
         chk("R9 map", 64'(map_phys_idx),
             64'((i < 32) ? i : 32 + ((i - 32 + rrb_exp) % 96)));
      end

      // R2 R10 collisions with a branch
      @(negedge clk);
      lc_wr_en = 1; lc_wr_data = 16'd3;
      @(negedge clk);
      lc_wr_en = 0;
      br_valid = 1; lc_wr_en = 1; lc_wr_data = 16'd7;
      pr_wr_en = 1; pr_wr_data = 64'h1 << 20;
      #1 chk("R3 taken old lc", 64'(br_taken), 64'd1);
      @(negedge clk);
      br_valid = 0; lc_wr_en = 0; pr_wr_en = 0;
      rrb_exp = (rrb_exp + 95) % 96;
      chk("R2 write wins", 64'(lc_q), 64'd7);
      chk("R10 write wins", pred_q, (64'h1 << 20) | 64'h1);
      chk("R10 rrb rotates", 64'(rrb_q), 64'(rrb_exp));

      // R11 idle hold
      snap_p = pred_q; snap_l = lc_q;
      repeat (5) @(negedge clk);
      chk("R11 lc hold", 64'(lc_q), 64'(snap_l));
      chk("R11 pred hold", pred_q, snap_p);
      chk("R11 rrb hold", 64'(rrb_q), 64'(rrb_exp));

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule